// File: doc/BRIEF.md
# Load-Store Address Generator

This block turns the decoded fields of a single-word load or store into the address that goes to memory and the value that may be written back into the base register. It receives a base value, an offset built from one of three sources, a direction flag and an indexing mode. From these it decides two things: whether the access uses the offset address or the untouched base, and whether the base register is updated.

All arithmetic wraps at the word width. The address used for the access must be word aligned. If it is not, the block raises a fault and suppresses the writeback. The outputs are registered, so every result appears one clock after its inputs. A decode stage drives the inputs every cycle, and the memory and register-file stages consume the outputs.

Top module: `ls_addr_gen`

## Requirements
- R1: With mode code 0 (offset access, base kept), the access address is base combined with the offset, and the writeback enable stays low.
- R2: With mode code 1 (offset access with update), the access address is base combined with the offset, the writeback enable is high, and the writeback value equals the access address.
- R3: With mode code 2 (access then update), the access address is the unmodified base, the writeback enable is high, and the writeback value is base combined with the offset.
- R4: The offset selector picks the offset source: code 0 is the 12-bit immediate, zero-extended; code 1 is the register offset; code 2 is the register offset shifted left by the shift amount, so a shift of 2 gives four times the register. Code 3 behaves as code 0.
- R5: When the subtract flag is 1, the offset is subtracted from the base. When it is 0, the offset is added. This holds for every offset source.
- R6: The alignment fault is raised exactly when the access address has either of its two low bits set. The writeback value does not affect the fault.
- R7: While the alignment fault is high, the writeback enable is low.
- R8: Address arithmetic wraps modulo 2^32, and a shift amount of 0 passes the register offset through unchanged.
- R9: Mode code 3 behaves as mode code 0.
- R10: All outputs are registered and reflect the inputs present at the previous rising clock edge. While the active-low reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseVal | input | 32 | Base register value |
| offSel | input | 2 | Offset source: 0 immediate, 1 register, 2 shifted register, 3 immediate |
| immOff | input | 12 | Immediate offset, zero-extended |
| regOff | input | 32 | Register offset value |
| shAmt | input | 5 | Left shift for the shifted-register form |
| subtract | input | 1 | 1 subtracts the offset, 0 adds it |
| idxMode | input | 2 | 0 offset access, 1 offset access with update, 2 access then update, 3 as 0 |
| accAddr | output | 32 | Address used for the memory access |
| wbEn | output | 1 | Base writeback enable |
| wbVal | output | 32 | New base value |
| alignFault | output | 1 | Access address is not word aligned |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 12-bit immediate, a 5-bit shift, two alignment bits and the shifted-register form enabled. These values make the wrap across the top of the 32-bit space reachable in both directions, along with the largest aligned immediate and shifts of 0, 2 and 4. Every combination of indexing mode and offset source can also be exercised. Misaligned cases are chosen so that the access address and the writeback value differ in alignment. This shows that the fault follows only the address actually used.

// File: rtl/ls_addr_gen_pkg.sv
package ls_addr_gen_pkg;

  typedef enum logic [1:0] {
    IDX_OFFSET    = 2'd0,
    IDX_OFFSET_WB = 2'd1,
    IDX_POST      = 2'd2,
    IDX_RSVD      = 2'd3
  } idxMode_e;

  typedef enum logic [1:0] {
    OFF_IMM   = 2'd0,
    OFF_REG   = 2'd1,
    OFF_SHREG = 2'd2,
    OFF_RSVD  = 2'd3
  } offSel_e;

  typedef struct packed {
    logic useSum;   // access address takes base combined with offset
    logic wbReq;    // base update requested by the mode
  } agCtrl_t;

endpackage

// File: rtl/ls_addr_gen_ctrl.sv
module ls_addr_gen_ctrl
  import ls_addr_gen_pkg::*;
(
  input  logic [1:0] idxMode,
  output agCtrl_t    ctrl
);

  always_comb begin
    ctrl = '0;
    unique case (idxMode_e'(idxMode))
      IDX_OFFSET:    begin ctrl.useSum = 1'b1; ctrl.wbReq = 1'b0; end
      IDX_OFFSET_WB: begin ctrl.useSum = 1'b1; ctrl.wbReq = 1'b1; end
      IDX_POST:      begin ctrl.useSum = 1'b0; ctrl.wbReq = 1'b1; end
      default:       begin ctrl.useSum = 1'b1; ctrl.wbReq = 1'b0; end // R9
    endcase
  end

endmodule

// File: rtl/ls_addr_gen_dp.sv
module ls_addr_gen_dp
  import ls_addr_gen_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int IMM_W      = 12,
  parameter int SHAMT_W    = 5,
  parameter int ALIGN_BITS = 2,
  parameter bit HAS_SCALED = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  agCtrl_t            ctrl,
  input  logic [WORD_W-1:0]  baseVal,
  input  logic [1:0]         offSel,
  input  logic [IMM_W-1:0]   immOff,
  input  logic [WORD_W-1:0]  regOff,
  input  logic [SHAMT_W-1:0] shAmt,
  input  logic               subtract,
  output logic [WORD_W-1:0]  accAddr,
  output logic               wbEn,
  output logic [WORD_W-1:0]  wbVal,
  output logic               alignFault
);

  localparam int IMM_PAD = WORD_W - IMM_W;

  logic [WORD_W-1:0] immExt;
  logic [WORD_W-1:0] scaledOff;
  logic [WORD_W-1:0] offVal;
  logic [WORD_W-1:0] sumVal;
  logic [WORD_W-1:0] addrNext;
  logic              faultNext;
  logic              primed;

  assign immExt = {{IMM_PAD{1'b0}}, immOff};

  generate
    if (HAS_SCALED) begin : g_scaled
      assign scaledOff = regOff << shAmt;
    end else begin : g_plain
      assign scaledOff = regOff;
    end
  endgenerate

  always_comb begin
    unique case (offSel_e'(offSel))
      OFF_REG:   offVal = regOff;
      OFF_SHREG: offVal = scaledOff;
      default:   offVal = immExt;
    endcase
  end

  assign sumVal    = subtract ? (baseVal - offVal) : (baseVal + offVal);
  assign addrNext  = ctrl.useSum ? sumVal : baseVal;
  assign faultNext = |addrNext[ALIGN_BITS-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accAddr    <= '0;
      wbVal      <= '0;
      wbEn       <= 1'b0;
      alignFault <= 1'b0;
      primed     <= 1'b0;
    end else begin
      accAddr    <= addrNext;
      wbVal      <= sumVal;
      wbEn       <= ctrl.wbReq & ~faultNext;
      alignFault <= faultNext;
      primed     <= 1'b1;
    end
  end

  assert_fault_blocks_wb_R7: assert property (@(posedge clk) disable iff (!rstN)
    alignFault |-> !wbEn);

  assert_fault_tracks_addr_R6: assert property (@(posedge clk) disable iff (!rstN)
    alignFault == (accAddr[ALIGN_BITS-1:0] != '0));

  assert_no_wb_offset_mode_R1: assert property (@(posedge clk) disable iff (!rstN)
    (primed && !$past(ctrl.wbReq)) |-> !wbEn);

  assert_post_uses_base_R3: assert property (@(posedge clk) disable iff (!rstN)
    (primed && !$past(ctrl.useSum)) |-> accAddr == $past(baseVal));

  assert_update_equals_addr_R2: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(ctrl.useSum) && wbEn) |-> wbVal == accAddr);

  assert_reset_quiet_R10: assert property (@(posedge clk)
    !$past(rstN) |-> (!wbEn && !alignFault));

endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
  import ls_addr_gen_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int IMM_W      = 12,
  parameter int SHAMT_W    = 5,
  parameter int ALIGN_BITS = 2,
  parameter bit HAS_SCALED = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WORD_W-1:0]  baseVal,
  input  logic [1:0]         offSel,
  input  logic [IMM_W-1:0]   immOff,
  input  logic [WORD_W-1:0]  regOff,
  input  logic [SHAMT_W-1:0] shAmt,
  input  logic               subtract,
  input  logic [1:0]         idxMode,
  output logic [WORD_W-1:0]  accAddr,
  output logic               wbEn,
  output logic [WORD_W-1:0]  wbVal,
  output logic               alignFault
);

  agCtrl_t ctrl;

  ls_addr_gen_ctrl u_ctrl (
    .idxMode (idxMode),
    .ctrl    (ctrl)
  );

  ls_addr_gen_dp #(
    .WORD_W     (WORD_W),
    .IMM_W      (IMM_W),
    .SHAMT_W    (SHAMT_W),
    .ALIGN_BITS (ALIGN_BITS),
    .HAS_SCALED (HAS_SCALED)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .baseVal    (baseVal),
    .offSel     (offSel),
    .immOff     (immOff),
    .regOff     (regOff),
    .shAmt      (shAmt),
    .subtract   (subtract),
    .accAddr    (accAddr),
    .wbEn       (wbEn),
    .wbVal      (wbVal),
    .alignFault (alignFault)
  );

endmodule

// File: tb/ls_addr_gen_bench.sv
module ls_addr_gen_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] baseVal = '0;
  logic [1:0]  offSel = '0;
  logic [11:0] immOff = '0;
  logic [31:0] regOff = '0;
  logic [4:0]  shAmt = '0;
  logic        subtract = 1'b0;
  logic [1:0]  idxMode = '0;
  logic [31:0] accAddr;
  logic        wbEn;
  logic [31:0] wbVal;
  logic        alignFault;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ls_addr_gen u_ls_addr_gen (
    .clk(clk), .rstN(rstN), .baseVal(baseVal), .offSel(offSel),
    .immOff(immOff), .regOff(regOff), .shAmt(shAmt), .subtract(subtract),
    .idxMode(idxMode), .accAddr(accAddr), .wbEn(wbEn), .wbVal(wbVal),
    .alignFault(alignFault)
  );

  // Drive one request at a negedge, sample one cycle later at the next negedge,
  // and compare against values worked out from the requirements.
  task automatic runCase(input string tag, input logic [1:0] mode,
                         input logic [1:0] sel, input logic [31:0] base,
                         input logic [11:0] imm, input logic [31:0] rOff,
                         input logic [4:0] sh, input logic sub,
                         input logic [31:0] expAddr, input logic expWb,
                         input logic [31:0] expWbVal, input logic expFault);
    idxMode = mode; offSel = sel; baseVal = base; immOff = imm;
    regOff = rOff; shAmt = sh; subtract = sub;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (accAddr !== expAddr || wbEn !== expWb || alignFault !== expFault ||
        (expWb && wbVal !== expWbVal)) begin
      failures++;
      $display("FAIL %s: addr=%h wbEn=%b wbVal=%h fault=%b expected addr=%h wbEn=%b wbVal=%h fault=%b",
               tag, accAddr, wbEn, wbVal, alignFault, expAddr, expWb, expWbVal, expFault);
    end
  endtask

  task automatic testReset();
    checks++;
    if (accAddr !== '0 || wbEn !== 1'b0 || wbVal !== '0 || alignFault !== 1'b0) begin
      failures++;
      $display("FAIL R10 reset: addr=%h wbEn=%b wbVal=%h fault=%b expected all zero",
               accAddr, wbEn, wbVal, alignFault);
    end
  endtask

  task automatic testModes();
    runCase("R1 offset imm add", 2'd0, 2'd0, 32'h0000_9000, 12'd4, 0, 0, 0,
            32'h0000_9004, 1'b0, 32'h0, 1'b0);
    runCase("R2 offset update", 2'd1, 2'd0, 32'h0000_9000, 12'd4, 0, 0, 0,
            32'h0000_9004, 1'b1, 32'h0000_9004, 1'b0);
    runCase("R3 post update", 2'd2, 2'd0, 32'h0000_9000, 12'd4, 0, 0, 0,
            32'h0000_9000, 1'b1, 32'h0000_9004, 1'b0);
    runCase("R9 mode 3 as offset", 2'd3, 2'd0, 32'h0000_9000, 12'd8, 0, 0, 0,
            32'h0000_9008, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic testOffsets();
    runCase("R5 reg sub", 2'd0, 2'd1, 32'h0000_0100, 12'd0, 32'h20, 0, 1,
            32'h0000_00E0, 1'b0, 32'h0, 1'b0);
    runCase("R4 scaled x4 post", 2'd2, 2'd2, 32'h0000_1000, 12'd0, 32'd3, 5'd2, 0,
            32'h0000_1000, 1'b1, 32'h0000_100C, 1'b0);
    runCase("R5 scaled sub update", 2'd1, 2'd2, 32'h0000_1000, 12'd0, 32'd1, 5'd4, 1,
            32'h0000_0FF0, 1'b1, 32'h0000_0FF0, 1'b0);
    runCase("R8 shift 0 passthrough", 2'd0, 2'd2, 32'h0000_2000, 12'd0, 32'd8, 5'd0, 0,
            32'h0000_2008, 1'b0, 32'h0, 1'b0);
    runCase("R4 imm zero-extended", 2'd1, 2'd0, 32'h0000_0000, 12'hFFC, 32'hFFFF_FFFF, 5'd3, 0,
            32'h0000_0FFC, 1'b1, 32'h0000_0FFC, 1'b0);
    runCase("R4 sel 3 as imm", 2'd0, 2'd3, 32'h0000_0040, 12'd16, 32'h100, 5'd1, 0,
            32'h0000_0050, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic testWrap();
    runCase("R8 wrap up", 2'd1, 2'd0, 32'hFFFF_FFFC, 12'd8, 0, 0, 0,
            32'h0000_0004, 1'b1, 32'h0000_0004, 1'b0);
    runCase("R8 wrap down", 2'd2, 2'd1, 32'h0000_0004, 12'd0, 32'd8, 0, 1,
            32'h0000_0004, 1'b1, 32'hFFFF_FFFC, 1'b0);
  endtask

  task automatic testAlign();
    runCase("R7 misaligned update", 2'd1, 2'd0, 32'h0000_9000, 12'd2, 0, 0, 0,
            32'h0000_9002, 1'b0, 32'h0, 1'b1);
    runCase("R6 post aligned access", 2'd2, 2'd0, 32'h0000_9000, 12'd2, 0, 0, 0,
            32'h0000_9000, 1'b1, 32'h0000_9002, 1'b0);
    runCase("R7 post misaligned base", 2'd2, 2'd0, 32'h0000_9001, 12'd3, 0, 0, 0,
            32'h0000_9001, 1'b0, 32'h0, 1'b1);
    runCase("R6 offset mode fault", 2'd0, 2'd1, 32'h0000_9000, 12'd0, 32'd1, 0, 1,
            32'h0000_8FFF, 1'b0, 32'h0, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    testReset();
    rstN = 1'b1;
    testModes();
    testOffsets();
    testWrap();
    testAlign();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule